// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block gathers seven event pulses from a serial bus controller into sticky status flags and turns them into one interrupt request line for the CPU. Each flag has its own enable bit. A vector output reports, as a small binary code, the highest-priority flag that is both pending and enabled, so an interrupt handler can tell at once what to service.

The handler reads the vector with a one-cycle read strobe. That read clears only the flag the vector names, and it takes the request line low for at least one clock. If other enabled flags are still pending, the line rises again as a fresh request, so a CPU input that reacts to edges sees a new event. Software can also clear flags by writing ones to the status write port. A software reset clears every flag and leaves the enable bits as they are.

Top module: `irq_vector_unit`

## Requirements
- R1: A one-cycle high on bit i of `evt_i` sets flag i on the next clock edge, whatever its enable bit is. The flag stays set until it is cleared. Bit map: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed-as-slave.
- R2: `vec_o` gives the code i+1 for the lowest-index flag that is both set and enabled, which makes it the highest priority. The codes are 1 for arbitration lost up to 7 for addressed-as-slave. `vec_o` is 0 when no enabled flag is pending.
- R3: A write with `mask_we_i` loads `mask_wdata_i` into the enable bits on the next edge, and `mask_o` shows them. A flag whose enable bit is 0 still shows in `flags_o`, but it never affects `vec_o` or `irq_o`.
- R4: `irq_o` is registered. In steady state it is high on the edge after any enabled flag is pending, and low on the edge after none is.
- R5: A vector read (`vec_rd_i` high for one cycle) clears, on that edge, only the flag named by `vec_o` in the read cycle. Every other flag keeps its value.
- R6: On the edge that samples a vector read, `irq_o` goes low. If enabled flags are still pending, it re-asserts on the following edge.
- R7: A write with `stat_we_i` clears every flag whose bit in `stat_wdata_i` is 1. It leaves the other flags unchanged.
- R8: When an event and a clear (status write or vector read) hit the same flag in the same cycle, the flag ends up set.
- R9: `soft_rst_i` clears all flags and `irq_o` on the next edge, even if events arrive in the same cycle. The enable bits keep their values.
- R10: A vector read while `vec_o` is 0 changes no flag, including flags whose enable bit is 0.
- R11: While `rst` is high, flags, enable bits and `irq_o` are 0 and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst_i | input | 1 | Software reset of the flags and request |
| evt_i | input | 7 | Event pulses, one bit per source |
| mask_we_i | input | 1 | Enable-bit write strobe |
| mask_wdata_i | input | 7 | New enable bits |
| stat_we_i | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata_i | input | 7 | Flags to clear |
| vec_rd_i | input | 1 | Vector read strobe |
| flags_o | output | 7 | Raw status flags |
| mask_o | output | 7 | Current enable bits |
| vec_o | output | 3 | Code of the highest-priority pending enabled flag |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The timing of each result is fixed:
- Flags, enable bits and the read-clear all take effect one edge after their strobe, and `vec_o` follows them in the same cycle because it is decoded without a register.
- `irq_o` comes one edge later than the flag that causes it, so it rises two edges after an event pulse.
- After a read, `irq_o` drops on the edge that samples the read and comes back one edge later.

The bench drives every input just after a falling edge. It checks the outputs at the next falling edge against a behavioural model that it updates on each rising edge. The directed checks are placed at the cycles worked out from these latencies.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

    localparam int IVU_NSRC   = 7;
    localparam int IVU_CODE_W = $clog2(IVU_NSRC + 1);

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_ARB_LOST = 3'd1,
        EV_NO_ACK   = 3'd2,
        EV_ACC_RDY  = 3'd3,
        EV_RX_RDY   = 3'd4,
        EV_TX_RDY   = 3'd5,
        EV_STOP     = 3'd6,
        EV_ADDR_HIT = 3'd7
    } ivu_code_e;

endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe_i,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flags_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || wipe_i) begin
                flags_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                flags_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flags_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ivu_prio_enc.sv
module ivu_prio_enc #(
    parameter int N_SRC  = 7,
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]  pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N_SRC-1:0]  pick_o
);

    always_comb begin
        code_o = '0;
        pick_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o = CODE_W'(i + 1);
                pick_o = '0;
                pick_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivu_req_gen.sv
module ivu_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic wipe_i,
    input  logic rd_i,
    input  logic any_pend_i,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (rst || wipe_i || rd_i) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_pend_i;
        end
    end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int N_SRC  = ivu_pkg::IVU_NSRC,
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              mask_we_i,
    input  logic [N_SRC-1:0]  mask_wdata_i,
    input  logic              stat_we_i,
    input  logic [N_SRC-1:0]  stat_wdata_i,
    input  logic              vec_rd_i,
    output logic [N_SRC-1:0]  flags_o,
    output logic [N_SRC-1:0]  mask_o,
    output logic [CODE_W-1:0] vec_o,
    output logic              irq_o
);

    logic [N_SRC-1:0] enable_q;
    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] pick;
    logic [N_SRC-1:0] clr_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (mask_we_i) begin
            enable_q <= mask_wdata_i;
        end
    end

    assign pending = flags_o & enable_q;

    ivu_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
        .pend_i (pending),
        .code_o (vec_o),
        .pick_o (pick)
    );

    always_comb begin
        clr_req = '0;
        if (stat_we_i) clr_req = clr_req | stat_wdata_i;
        if (vec_rd_i)  clr_req = clr_req | pick;
    end

    ivu_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .wipe_i  (soft_rst_i),
        .set_i   (evt_i),
        .clr_i   (clr_req),
        .flags_o (flags_o)
    );

    ivu_req_gen u_req (
        .clk        (clk),
        .rst        (rst),
        .wipe_i     (soft_rst_i),
        .rd_i       (vec_rd_i),
        .any_pend_i (|pending),
        .irq_o      (irq_o)
    );

    assign mask_o = enable_q;

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
    parameter int N_SRC  = 7,
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst_i,
    input logic [N_SRC-1:0]  evt_i,
    input logic              vec_rd_i,
    input logic [N_SRC-1:0]  flags_o,
    input logic [N_SRC-1:0]  mask_o,
    input logic [CODE_W-1:0] vec_o,
    input logic              irq_o
);

    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] lower;

    always_comb begin
        hit   = (vec_o == '0) ? '0 : (N_SRC'(1) << (vec_o - CODE_W'(1)));
        lower = (vec_o == '0) ? '0 : (hit - N_SRC'(1));
    end

    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i && !soft_rst_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    // R1
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_o & ~$past(flags_o) & ~$past(evt_i)) == '0);

    // R2
    vec_matches_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_o != '0) == (|(flags_o & mask_o)));

    // R2
    vec_highest_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_o != '0) |-> (((flags_o & mask_o & lower) == '0) && ((flags_o & mask_o & hit) == hit)));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_i && !soft_rst_i) |=> ((flags_o & $past(hit & ~evt_i)) == '0));

    // R6
    read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_i |=> !irq_o);

    // R4
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(flags_o & mask_o)));

    // R9
    soft_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (flags_o == '0 && !irq_o));

endmodule

bind irq_vector_unit irq_vector_chk #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst_i (soft_rst_i),
    .evt_i      (evt_i),
    .vec_rd_i   (vec_rd_i),
    .flags_o    (flags_o),
    .mask_o     (mask_o),
    .vec_o      (vec_o),
    .irq_o      (irq_o)
);

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;

    localparam int N = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst_i = 1'b0;
    logic [6:0] evt_i = '0;
    logic       mask_we_i = 1'b0;
    logic [6:0] mask_wdata_i = '0;
    logic       stat_we_i = 1'b0;
    logic [6:0] stat_wdata_i = '0;
    logic       vec_rd_i = 1'b0;
    logic [6:0] flags_o;
    logic [6:0] mask_o;
    logic [2:0] vec_o;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [6:0] m_flags = '0;
    logic [6:0] m_mask = '0;
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;

    irq_vector_unit u_irq_vector_unit (
        .clk          (clk),
        .rst          (rst),
        .soft_rst_i   (soft_rst_i),
        .evt_i        (evt_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .stat_we_i    (stat_we_i),
        .stat_wdata_i (stat_wdata_i),
        .vec_rd_i     (vec_rd_i),
        .flags_o      (flags_o),
        .mask_o       (mask_o),
        .vec_o        (vec_o),
        .irq_o        (irq_o)
    );

    function automatic int model_vec(input logic [6:0] f, input logic [6:0] m);
        for (int i = 0; i < N; i++) begin
            if (f[i] && m[i]) return i + 1;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int top;
        logic [6:0] nf;
        if (rst) begin
            m_flags = '0;
            m_mask  = '0;
            m_irq   = 1'b0;
        end else begin
            top = model_vec(m_flags, m_mask);
            nf = m_flags;
            if (vec_rd_i && top != 0) nf[top-1] = 1'b0;
            if (stat_we_i) nf = nf & ~stat_wdata_i;
            nf = nf | evt_i;
            if (soft_rst_i) nf = '0;
            m_irq = (soft_rst_i || vec_rd_i) ? 1'b0 : ((m_flags & m_mask) != '0);
            m_flags = nf;
            if (mask_we_i) m_mask = mask_wdata_i;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 flags vs model", int'(flags_o), int'(m_flags));
            chk("R3 mask vs model", int'(mask_o), int'(m_mask));
            chk("R2 vector vs model", int'(vec_o), model_vec(m_flags, m_mask));
            chk("R4 request vs model", int'(irq_o), int'(m_irq));
        end
    end

    task automatic step(input logic [6:0] ev, input logic mwe, input logic [6:0] md,
                        input logic swe, input logic [6:0] sd, input logic rd,
                        input logic sr);
        evt_i = ev; mask_we_i = mwe; mask_wdata_i = md;
        stat_we_i = swe; stat_wdata_i = sd; vec_rd_i = rd; soft_rst_i = sr;
        @(negedge clk);
        evt_i = '0; mask_we_i = 1'b0; stat_we_i = 1'b0; vec_rd_i = 1'b0; soft_rst_i = 1'b0;
        #1;
    endtask

    task automatic idle();
        step('0, 0, '0, 0, '0, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 flags in reset", int'(flags_o), 0);
        chk("R11 mask in reset", int'(mask_o), 0);
        chk("R11 irq in reset", int'(irq_o), 0);
        chk("R11 vec in reset", int'(vec_o), 0);
        rst = 1'b0;
        #1;

        step('0, 1, 7'h7F, 0, '0, 0, 0);
        chk("R3 mask load", int'(mask_o), 'h7F);
        step(7'h44, 0, '0, 0, '0, 0, 0);
        chk("R1 flags set", int'(flags_o), 'h44);
        chk("R2 vec access ready", int'(vec_o), 3);
        chk("R4 irq not yet", int'(irq_o), 0);
        idle();
        chk("R4 irq raised", int'(irq_o), 1);
        chk("R5 vec before read", int'(vec_o), 3);
        step('0, 0, '0, 0, '0, 1, 0);
        chk("R5 only top flag cleared", int'(flags_o), 'h40);
        chk("R6 irq dropped", int'(irq_o), 0);
        idle();
        chk("R6 irq re-raised", int'(irq_o), 1);
        chk("R2 vec addressed", int'(vec_o), 7);
        step('0, 0, '0, 0, '0, 1, 0);
        idle();
        chk("R6 no re-raise when empty", int'(irq_o), 0);

        // masked source
        step('0, 1, 7'h01, 0, '0, 0, 0);
        step(7'h02, 0, '0, 0, '0, 0, 0);
        chk("R3 masked flag visible", int'(flags_o), 'h02);
        chk("R3 masked vec zero", int'(vec_o), 0);
        idle();
        chk("R3 masked no irq", int'(irq_o), 0);
        step('0, 0, '0, 0, '0, 1, 0);
        chk("R10 empty read keeps flags", int'(flags_o), 'h02);
        step('0, 0, '0, 1, 7'h02, 0, 0);
        chk("R7 write clear", int'(flags_o), 0);

        // set wins
        step(7'h08, 0, '0, 0, '0, 0, 0);
        step(7'h08, 0, '0, 1, 7'h08, 0, 0);
        chk("R8 set beats write clear", int'(flags_o), 'h08);
        step('0, 1, 7'h7F, 0, '0, 0, 0);
        chk("R2 vec receive ready", int'(vec_o), 4);
        step(7'h08, 0, '0, 0, '0, 1, 0);
        chk("R8 set beats read clear", int'(flags_o), 'h08);
        chk("R6 irq low after read", int'(irq_o), 0);

        // soft reset
        step(7'h10, 0, '0, 0, '0, 0, 0);
        chk("R1 second flag", int'(flags_o), 'h18);
        step(7'h01, 0, '0, 0, '0, 0, 1);
        chk("R9 flags wiped", int'(flags_o), 0);
        chk("R9 irq wiped", int'(irq_o), 0);
        chk("R9 mask kept", int'(mask_o), 'h7F);

        // drain all seven in priority order
        step(7'h7F, 0, '0, 0, '0, 0, 0);
        for (int k = 1; k <= N; k++) begin
            chk("R2 priority order", int'(vec_o), k);
            step('0, 0, '0, 0, '0, 1, 0);
        end
        chk("R5 all drained", int'(flags_o), 0);

        // random phase, compared against the model every cycle
        lfsr = 16'hACE1;
        for (int c = 0; c < 2000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[6:0] & lfsr[13:7] & {7{lfsr[2]}},
                 lfsr[15:12] == 4'h0, lfsr[10:4],
                 lfsr[11:9] == 3'h0, lfsr[8:2],
                 lfsr[14] & lfsr[3],
                 lfsr[15:10] == 6'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule